// File: doc/BRIEF.md
# AAL5 Common-Part Reassembly Checker and Trailer Builder

This block handles the common part of the AAL5 convergence sublayer for a single connection, one byte per clock. On the receive side it takes the 48-byte payloads of consecutive cells. Each cell carries a per-cell end-of-PDU mark, a cell-loss-priority flag and a congestion flag. The block runs a CRC-32 across every byte of the PDU and forwards every byte that is not part of the 8-byte trailer. When the final cell completes, it reports a status word. That word carries the trailer's user-to-user byte, the common-part indicator and the length field, the accumulated CLP and congestion state, and separate CRC, length, CPI and abort flags. The consumer uses the reported length to drop the pad bytes from the forwarded stream.

The transmit side takes a payload byte stream from its user, together with a user-to-user byte. It emits a cell-aligned byte stream, adding zero pad so that the 8-byte trailer closes a cell. The trailer holds the user byte, a zero CPI, the payload length and the complemented CRC-32. It marks the end of every cell and the end of the PDU, so that the cell builder downstream can set the end-of-PDU mark.

All four byte streams use valid/ready. A byte moves only on a clock edge where valid and ready are both high. The sender holds its byte and flags stable until that edge. Both output streams are registered. An output byte that is stalled stays unchanged until it is taken. Each input ready is low while its output register is full and the consumer is not taking the byte. The transmit input ready is also low while pad or trailer bytes are being produced. The status word is a one-cycle pulse on `st_valid` and has no ready.

Top module: `aal5_cpcs`

## Requirements
- R1: Receive bytes are counted in cells of 48. Every byte is forwarded on `rxo_*` in order, except positions 40 to 47 of a cell whose end mark is set. In an ended cell, `rxo_last` is high on the byte at position 39.
- R2: Receive back-pressure: while `rxo_valid` is high and `rxo_ready` is low, `rxo_data` and `rxo_last` hold. No byte is lost or repeated.
- R3: One cycle after position 47 of an ended cell is accepted, `st_valid` pulses for one cycle. The pulse carries UU from position 40, CPI from position 41 and the length from positions 42 (high byte) and 43 (low byte).
- R4: The receive CRC-32 uses polynomial 0x04C11DB7, starts at all ones and is taken MSB first over all bytes of the PDU, trailer included. `st_crc_err` is set when the final value differs from 0xC704DD7B.
- R5: `st_cpi_err` is set when the received CPI byte is not zero.
- R6: Let N be 48 times the number of cells in the PDU. `st_len_err` is set when the length field is zero, when it exceeds N-8, or when N-8 minus the length exceeds 47.
- R7: `rx_pdu_end`, `rx_clp` and `rx_ci` are sampled on position 0 of each cell. `st_clp` and `st_ci` report the OR of the sampled flags over all cells of the PDU.
- R8: A PDU ends with an abort when MAX_CELLS cells are accepted and none carries the end mark. Then `rxo_last` is set on position 47 of the last cell, `st_abort` is 1, the CRC, length and CPI flags are 0, UU, CPI and length read 0, and the next cell starts a new PDU.
- R9: The transmit output is the payload, then zero pad, then UU (from `tx_uu` on the byte with `tx_last`), CPI 0, the 16-bit payload length high byte first, and the complemented CRC-32 high byte first. The pad is sized so that the last trailer byte is at position 47 of a cell.
- R10: `txo_cell_end` is high on every byte at position 47. `txo_pdu_end` is high only on the final trailer byte.
- R11: `tx_ready` is high only while payload is being taken and the output register can load. While `txo_valid` is high and `txo_ready` is low, the output byte and its flags hold.
- R12: After reset `rxo_valid`, `txo_valid` and `st_valid` are low, and both `rx_ready` and `tx_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Receive byte accepted when high with valid |
| rx_data | input | 8 | Receive cell payload byte |
| rx_pdu_end | input | 1 | End-of-PDU mark of the cell, sampled at position 0 |
| rx_clp | input | 1 | Cell loss priority of the cell, sampled at position 0 |
| rx_ci | input | 1 | Congestion indication of the cell, sampled at position 0 |
| rxo_valid | output | 1 | Forwarded byte valid |
| rxo_ready | input | 1 | Consumer takes forwarded byte |
| rxo_data | output | 8 | Forwarded payload or pad byte |
| rxo_last | output | 1 | Final forwarded byte of the PDU |
| st_valid | output | 1 | One-cycle status pulse |
| st_uu | output | 8 | Received user-to-user byte |
| st_cpi | output | 8 | Received CPI byte |
| st_len | output | 16 | Received length field |
| st_clp | output | 1 | OR of cell CLP flags |
| st_ci | output | 1 | OR of cell congestion flags |
| st_crc_err | output | 1 | CRC-32 mismatch |
| st_len_err | output | 1 | Length field inconsistent |
| st_cpi_err | output | 1 | Nonzero CPI |
| st_abort | output | 1 | PDU exceeded MAX_CELLS |
| tx_valid | input | 1 | Transmit payload byte valid |
| tx_ready | output | 1 | Transmit payload byte accepted when high with valid |
| tx_data | input | 8 | Transmit payload byte |
| tx_last | input | 1 | Final payload byte of the PDU |
| tx_uu | input | 8 | User-to-user byte, sampled with tx_last |
| txo_valid | output | 1 | Cell-stream byte valid |
| txo_ready | input | 1 | Downstream takes cell-stream byte |
| txo_data | output | 8 | Payload, pad or trailer byte |
| txo_cell_end | output | 1 | Byte at position 47 of a cell |
| txo_pdu_end | output | 1 | Final byte of the PDU |

## Verification
The assertions check the following on every cycle: held output bytes during stalls on both streams, status pulses that never come back to back, clean fields on an aborted PDU, a PDU end that always closes a cell, a zero length field always raising the length flag, and the transmit ready depending on the output register. The bench scenarios cover the rest, because it depends on byte contents across a whole PDU. That includes the CRC residue, pad sizing for payloads that do and do not leave room for the trailer, the three length failure cases, the CLP and congestion OR across cells, and recovery after an abort.

// File: rtl/aal5_pkg.sv
package aal5_pkg;
  localparam int CELL_BYTES = 48;
  localparam int TRL_BYTES  = 8;
  localparam int TRL_START  = CELL_BYTES - TRL_BYTES;
  localparam int POS_W      = $clog2(CELL_BYTES);
  localparam int LEN_W      = 16;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_GOOD = 32'hC704_DD7B;

  typedef enum logic [1:0] {TX_DATA, TX_PAD, TX_TRL} tx_state_e;

  // one byte of CRC-32, most significant data bit first
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = (r << 1) ^ CRC_POLY;
      else              r = r << 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/aal5_crc_reg.sv
module aal5_crc_reg
  import aal5_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        start,
  input  logic [7:0]  data,
  output logic [31:0] crc_q
);
  logic [31:0] crc_nxt;
  assign crc_nxt = crc_step(start ? 32'hFFFF_FFFF : crc_q, data);

  always_ff @(posedge clk) begin
    if (!rst_n)  crc_q <= 32'hFFFF_FFFF;
    else if (en) crc_q <= crc_nxt;
  end
endmodule

// File: rtl/aal5_rx_reasm.sv
module aal5_rx_reasm
  import aal5_pkg::*;
#(
  parameter int MAX_CELLS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_end,
  input  logic             in_clp,
  input  logic             in_ci,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             st_valid,
  output logic [7:0]       st_uu,
  output logic [7:0]       st_cpi,
  output logic [LEN_W-1:0] st_len,
  output logic             st_clp,
  output logic             st_ci,
  output logic             st_crc_err,
  output logic             st_len_err,
  output logic             st_cpi_err,
  output logic             st_abort
);
  localparam int CW = $clog2(MAX_CELLS);

  logic [POS_W-1:0] pos;
  logic [CW-1:0]    cells;
  logic             first, cur_end, clp_acc, ci_acc;
  logic [7:0]       uu_q, cpi_q;
  logic [LEN_W-1:0] len_q;
  logic [31:0]      crc_q;

  logic acc, eop_now, trl, cell_last, at_max, abort_now, finish, crc_ok, len_bad;
  logic [31:0] avail, len32;

  assign in_ready  = !out_valid || out_ready;
  assign acc       = in_valid && in_ready;
  assign eop_now   = (pos == '0) ? in_end : cur_end;
  assign trl       = eop_now && (pos >= POS_W'(TRL_START));
  assign cell_last = (pos == POS_W'(CELL_BYTES - 1));
  assign at_max    = (cells == CW'(MAX_CELLS - 1));
  assign abort_now = cell_last && !eop_now && at_max;
  assign finish    = acc && cell_last && (eop_now || at_max);
  assign crc_ok    = (crc_step(crc_q, in_data) == CRC_GOOD);

  assign avail   = ({{(32-CW){1'b0}}, cells} + 32'd1) * 32'(CELL_BYTES) - 32'(TRL_BYTES);
  assign len32   = {{(32-LEN_W){1'b0}}, len_q};
  assign len_bad = (len_q == '0) || (len32 > avail) || ((avail - len32) > 32'(CELL_BYTES - 1));

  aal5_crc_reg u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (acc),
    .start (first),
    .data  (in_data),
    .crc_q (crc_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0; cells <= '0; first <= 1'b1; cur_end <= 1'b0;
      clp_acc <= 1'b0; ci_acc <= 1'b0;
      uu_q <= '0; cpi_q <= '0; len_q <= '0;
    end else if (acc) begin
      pos   <= cell_last ? '0 : pos + 1'b1;
      first <= finish;
      if (pos == '0) begin
        cur_end <= in_end;
        clp_acc <= (first ? 1'b0 : clp_acc) | in_clp;
        ci_acc  <= (first ? 1'b0 : ci_acc)  | in_ci;
      end
      if (finish)         cells <= '0;
      else if (cell_last) cells <= cells + 1'b1;
      if (eop_now) begin
        if (pos == POS_W'(TRL_START))     uu_q  <= in_data;
        if (pos == POS_W'(TRL_START + 1)) cpi_q <= in_data;
        if (pos == POS_W'(TRL_START + 2) || pos == POS_W'(TRL_START + 3))
          len_q <= {len_q[7:0], in_data};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_data <= '0; out_last <= 1'b0;
    end else if (acc && !trl) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
      out_last  <= (eop_now && pos == POS_W'(TRL_START - 1)) || abort_now;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid <= 1'b0; st_uu <= '0; st_cpi <= '0; st_len <= '0;
      st_clp <= 1'b0; st_ci <= 1'b0; st_crc_err <= 1'b0;
      st_len_err <= 1'b0; st_cpi_err <= 1'b0; st_abort <= 1'b0;
    end else begin
      st_valid <= finish;
      if (finish) begin
        st_uu      <= abort_now ? '0 : uu_q;
        st_cpi     <= abort_now ? '0 : cpi_q;
        st_len     <= abort_now ? '0 : len_q;
        st_clp     <= clp_acc;
        st_ci      <= ci_acc;
        st_crc_err <= !abort_now && !crc_ok;
        st_len_err <= !abort_now && len_bad;
        st_cpi_err <= !abort_now && (cpi_q != '0);
        st_abort   <= abort_now;
      end
    end
  end
endmodule

// File: rtl/aal5_tx_frame.sv
module aal5_tx_frame
  import aal5_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic [7:0] in_uu,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_cell_end,
  output logic       out_pdu_end
);
  tx_state_e        st;
  logic [POS_W-1:0] pos;
  logic             first;
  logic [LEN_W-1:0] len_q;
  logic [7:0]       uu_q, nbyte;
  logic [31:0]      crc_q, crc_inv;
  logic [2:0]       tidx;
  logic             load_ok, step, cell_last, crc_en;

  assign load_ok   = !out_valid || out_ready;
  assign in_ready  = (st == TX_DATA) && load_ok;
  assign step      = (st == TX_DATA) ? (in_valid && load_ok) : load_ok;
  assign cell_last = (pos == POS_W'(CELL_BYTES - 1));
  assign tidx      = 3'(pos - POS_W'(TRL_START));
  assign crc_inv   = ~crc_q;
  assign crc_en    = step && !(st == TX_TRL && tidx[2]);

  always_comb begin
    nbyte = 8'h00;
    case (st)
      TX_DATA: nbyte = in_data;
      TX_PAD:  nbyte = 8'h00;
      default: begin
        case (tidx)
          3'd0: nbyte = uu_q;
          3'd1: nbyte = 8'h00;
          3'd2: nbyte = len_q[15:8];
          3'd3: nbyte = len_q[7:0];
          3'd4: nbyte = crc_inv[31:24];
          3'd5: nbyte = crc_inv[23:16];
          3'd6: nbyte = crc_inv[15:8];
          default: nbyte = crc_inv[7:0];
        endcase
      end
    endcase
  end

  aal5_crc_reg u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (crc_en),
    .start (first),
    .data  (nbyte),
    .crc_q (crc_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= TX_DATA; pos <= '0; first <= 1'b1; len_q <= '0; uu_q <= '0;
    end else if (step) begin
      pos <= cell_last ? '0 : pos + 1'b1;
      case (st)
        TX_DATA: begin
          first <= 1'b0;
          len_q <= first ? LEN_W'(1) : len_q + 1'b1;
          if (in_last) begin
            uu_q <= in_uu;
            st   <= (pos == POS_W'(TRL_START - 1)) ? TX_TRL : TX_PAD;
          end
        end
        TX_PAD: if (pos == POS_W'(TRL_START - 1)) st <= TX_TRL;
        default: if (cell_last) begin
          st    <= TX_DATA;
          first <= 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_data <= '0; out_cell_end <= 1'b0; out_pdu_end <= 1'b0;
    end else if (step) begin
      out_valid    <= 1'b1;
      out_data     <= nbyte;
      out_cell_end <= cell_last;
      out_pdu_end  <= (st == TX_TRL) && cell_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/aal5_cpcs.sv
module aal5_cpcs
  import aal5_pkg::*;
#(
  parameter int MAX_CELLS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_pdu_end,
  input  logic        rx_clp,
  input  logic        rx_ci,
  output logic        rxo_valid,
  input  logic        rxo_ready,
  output logic [7:0]  rxo_data,
  output logic        rxo_last,
  output logic        st_valid,
  output logic [7:0]  st_uu,
  output logic [7:0]  st_cpi,
  output logic [15:0] st_len,
  output logic        st_clp,
  output logic        st_ci,
  output logic        st_crc_err,
  output logic        st_len_err,
  output logic        st_cpi_err,
  output logic        st_abort,
  input  logic        tx_valid,
  output logic        tx_ready,
  input  logic [7:0]  tx_data,
  input  logic        tx_last,
  input  logic [7:0]  tx_uu,
  output logic        txo_valid,
  input  logic        txo_ready,
  output logic [7:0]  txo_data,
  output logic        txo_cell_end,
  output logic        txo_pdu_end
);
  aal5_rx_reasm #(.MAX_CELLS(MAX_CELLS)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (rx_valid),
    .in_ready   (rx_ready),
    .in_data    (rx_data),
    .in_end     (rx_pdu_end),
    .in_clp     (rx_clp),
    .in_ci      (rx_ci),
    .out_valid  (rxo_valid),
    .out_ready  (rxo_ready),
    .out_data   (rxo_data),
    .out_last   (rxo_last),
    .st_valid   (st_valid),
    .st_uu      (st_uu),
    .st_cpi     (st_cpi),
    .st_len     (st_len),
    .st_clp     (st_clp),
    .st_ci      (st_ci),
    .st_crc_err (st_crc_err),
    .st_len_err (st_len_err),
    .st_cpi_err (st_cpi_err),
    .st_abort   (st_abort)
  );

  aal5_tx_frame u_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (tx_valid),
    .in_ready     (tx_ready),
    .in_data      (tx_data),
    .in_last      (tx_last),
    .in_uu        (tx_uu),
    .out_valid    (txo_valid),
    .out_ready    (txo_ready),
    .out_data     (txo_data),
    .out_cell_end (txo_cell_end),
    .out_pdu_end  (txo_pdu_end)
  );
endmodule

// File: rtl/aal5_cpcs_chk.sv
module aal5_cpcs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rxo_valid,
  input logic        rxo_ready,
  input logic [7:0]  rxo_data,
  input logic        rxo_last,
  input logic        st_valid,
  input logic        st_abort,
  input logic        st_crc_err,
  input logic        st_len_err,
  input logic        st_cpi_err,
  input logic [15:0] st_len,
  input logic        tx_ready,
  input logic        txo_valid,
  input logic        txo_ready,
  input logic [7:0]  txo_data,
  input logic        txo_cell_end,
  input logic        txo_pdu_end
);
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rxo_valid && !rxo_ready |=> rxo_valid && $stable(rxo_data) && $stable(rxo_last)); // R2

  AST_ST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> !st_valid); // R3

  AST_LEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_abort && st_len == 16'd0 |-> st_len_err); // R6

  AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_abort |-> !st_crc_err && !st_len_err && !st_cpi_err && st_len == 16'd0); // R8

  AST_PDU_END_CELL: assert property (@(posedge clk) disable iff (!rst_n)
    txo_valid && txo_pdu_end |-> txo_cell_end); // R10

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    txo_valid && !txo_ready |=> txo_valid && $stable(txo_data) && $stable(txo_cell_end)
                                && $stable(txo_pdu_end)); // R11

  AST_TX_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !txo_valid || txo_ready); // R11
endmodule

bind aal5_cpcs aal5_cpcs_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rxo_valid    (rxo_valid),
  .rxo_ready    (rxo_ready),
  .rxo_data     (rxo_data),
  .rxo_last     (rxo_last),
  .st_valid     (st_valid),
  .st_abort     (st_abort),
  .st_crc_err   (st_crc_err),
  .st_len_err   (st_len_err),
  .st_cpi_err   (st_cpi_err),
  .st_len       (st_len),
  .tx_ready     (tx_ready),
  .txo_valid    (txo_valid),
  .txo_ready    (txo_ready),
  .txo_data     (txo_data),
  .txo_cell_end (txo_cell_end),
  .txo_pdu_end  (txo_pdu_end)
);

// File: tb/test_aal5_cpcs.sv
`timescale 1ns/1ps
module test_aal5_cpcs;
  localparam int MAXC = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;
  logic rst_n = 1'b0;

  logic        rx_valid = 0, rx_pdu_end = 0, rx_clp = 0, rx_ci = 0, rxo_ready = 0;
  logic [7:0]  rx_data = 0;
  logic        rx_ready, rxo_valid, rxo_last, st_valid, st_clp, st_ci;
  logic        st_crc_err, st_len_err, st_cpi_err, st_abort;
  logic [7:0]  rxo_data, st_uu, st_cpi;
  logic [15:0] st_len;
  logic        tx_valid = 0, tx_last = 0, txo_ready = 0;
  logic [7:0]  tx_data = 0, tx_uu = 0;
  logic        tx_ready, txo_valid, txo_cell_end, txo_pdu_end;
  logic [7:0]  txo_data;

  aal5_cpcs #(.MAX_CELLS(MAXC)) i_aal5_cpcs (.*);

  int n_chk = 0, n_bad = 0;
  logic [7:0]  frame[$];
  logic [9:0]  exp_tx[$];   // {cell_end, pdu_end, data}
  logic [8:0]  exp_rx[$];   // {last, data}
  logic [37:0] exp_st[$];   // {uu, cpi, len, clp, ci, crc, len, cpi, abort}

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = r[31] ^ b[7-i];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  // payload, zero pad, trailer: uu, cpi, length, complemented CRC
  task automatic make_frame(input int plen, input logic [7:0] uu, input logic [7:0] cpi,
                            input int len_fld, input int seed);
    int total;
    logic [31:0] c;
    logic [15:0] lf;
    frame.delete();
    total = ((plen + 8 + 47) / 48) * 48;
    lf = (len_fld < 0) ? 16'(plen) : 16'(len_fld);
    for (int i = 0; i < plen; i++) frame.push_back(8'(i * 13 + seed));
    while (frame.size() < total - 8) frame.push_back(8'h00);
    frame.push_back(uu); frame.push_back(cpi);
    frame.push_back(lf[15:8]); frame.push_back(lf[7:0]);
    c = 32'hFFFF_FFFF;
    foreach (frame[i]) c = crc_upd(c, frame[i]);
    c = ~c;
    frame.push_back(c[31:24]); frame.push_back(c[23:16]);
    frame.push_back(c[15:8]);  frame.push_back(c[7:0]);
  endtask

  task automatic drive_tx(input logic [7:0] d, input logic l, input logic [7:0] u);
    @(negedge clk);
    tx_valid = 1; tx_data = d; tx_last = l; tx_uu = u;
    #3;
    while (!tx_ready) begin @(negedge clk); #3; end
    @(posedge clk); #1;
    tx_valid = 0;
    if ($urandom_range(0, 7) == 0) @(negedge clk);
  endtask

  task automatic drive_rx(input logic [7:0] d, input logic e, input logic c, input logic g);
    @(negedge clk);
    rx_valid = 1; rx_data = d; rx_pdu_end = e; rx_clp = c; rx_ci = g;
    #3;
    while (!rx_ready) begin @(negedge clk); #3; end
    @(posedge clk); #1;
    rx_valid = 0;
    if ($urandom_range(0, 7) == 0) @(negedge clk);
  endtask

  // R9 R10: expected cell stream from the bench's own framing
  task automatic tx_pdu(input int plen, input logic [7:0] uu, input int seed);
    make_frame(plen, uu, 8'h00, -1, seed);
    foreach (frame[i])
      exp_tx.push_back({(i % 48) == 47, i == frame.size() - 1, frame[i]});
    for (int i = 0; i < plen; i++) drive_tx(frame[i], i == plen - 1, uu);
  endtask

  // feeds the current frame; expected status from R3..R7
  task automatic rx_pdu(input int clpmask, input int cimask);
    int n, nc, avail;
    logic [31:0] c;
    logic [15:0] lf;
    logic clp, ci, lbad;
    n = frame.size(); nc = n / 48; avail = n - 8;
    for (int i = 0; i < n - 8; i++) exp_rx.push_back({i == n - 9, frame[i]});
    c = 32'hFFFF_FFFF;
    foreach (frame[i]) c = crc_upd(c, frame[i]);
    lf = {frame[n-6], frame[n-5]};
    lbad = (lf == 0) || (int'(lf) > avail) || (avail - int'(lf) > 47);
    clp = ((clpmask & ((1 << nc) - 1)) != 0);
    ci  = ((cimask  & ((1 << nc) - 1)) != 0);
    exp_st.push_back({frame[n-8], frame[n-7], lf, clp, ci, c != 32'hC704DD7B, lbad,
                      frame[n-7] != 8'h00, 1'b0});
    for (int i = 0; i < n; i++)
      drive_rx(frame[i], (i / 48) == nc - 1, clpmask[i / 48], cimask[i / 48]);
  endtask

  // R8: MAXC cells without an end mark
  task automatic rx_abort(input int clpmask);
    int n;
    n = MAXC * 48;
    for (int i = 0; i < n; i++) exp_rx.push_back({i == n - 1, 8'(i * 5 + 1)});
    exp_st.push_back({8'h00, 8'h00, 16'h0000, clpmask[MAXC-1:0] != 0, 1'b0,
                      1'b0, 1'b0, 1'b0, 1'b1});
    for (int i = 0; i < n; i++) drive_rx(8'(i * 5 + 1), 1'b0, clpmask[i / 48], 1'b0);
  endtask

  // monitor: random back-pressure, scoreboard pops, hold checks
  initial begin
    logic rx_stall, tx_stall;
    logic [8:0] rx_prev;
    logic [9:0] tx_prev;
    rx_stall = 0; tx_stall = 0; rx_prev = 0; tx_prev = 0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      rxo_ready = ($urandom_range(0, 3) != 0);
      txo_ready = ($urandom_range(0, 3) != 0);
      #3;
      if (rx_stall) check("R2 rx hold", {rxo_valid, rxo_last, rxo_data}, {1'b1, rx_prev});
      if (tx_stall) check("R11 tx hold", {txo_valid, txo_cell_end, txo_pdu_end, txo_data},
                          {1'b1, tx_prev});
      rx_stall = rxo_valid && !rxo_ready;
      tx_stall = txo_valid && !txo_ready;
      rx_prev  = {rxo_last, rxo_data};
      tx_prev  = {txo_cell_end, txo_pdu_end, txo_data};
      if (rxo_valid && rxo_ready) begin
        if (exp_rx.size() == 0) check("R1 unexpected rx byte", 1, 0);
        else check("R1 rx byte", {rxo_last, rxo_data}, exp_rx.pop_front());
      end
      if (txo_valid && txo_ready) begin
        if (exp_tx.size() == 0) check("R9 unexpected tx byte", 1, 0);
        else check("R9 R10 tx byte", {txo_cell_end, txo_pdu_end, txo_data}, exp_tx.pop_front());
      end
      if (st_valid) begin
        if (exp_st.size() == 0) check("R3 unexpected status", 1, 0);
        else begin
          logic [37:0] e;
          e = exp_st.pop_front();
          check("R3 uu/cpi/len", {st_uu, st_cpi, st_len}, e[37:6]);
          check("R7 clp/ci", {st_clp, st_ci}, e[5:4]);
          check("R4 crc_err", st_crc_err, e[3]);
          check("R6 len_err", st_len_err, e[2]);
          check("R5 cpi_err", st_cpi_err, e[1]);
          check("R8 abort", st_abort, e[0]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #3;
    check("R12 reset valids", {rxo_valid, txo_valid, st_valid}, 3'b000);
    check("R12 reset readies", {rx_ready, tx_ready}, 2'b11);

    // transmit framing: zero pad, full pad, pad across cells
    tx_pdu(1,   8'hA5, 3);
    tx_pdu(40,  8'h11, 7);
    tx_pdu(41,  8'h22, 9);
    tx_pdu(39,  8'h33, 2);
    tx_pdu(100, 8'h44, 5);
    tx_pdu(47,  8'h55, 1);

    // receive good PDUs, CLP and congestion over cells
    make_frame(40, 8'h5A, 8'h00, -1, 4);  rx_pdu(0, 0);
    make_frame(100, 8'hC3, 8'h00, -1, 8); rx_pdu(2, 0);
    make_frame(41, 8'h01, 8'h00, -1, 6);  rx_pdu(0, 1);
    // R4 corrupted payload byte
    make_frame(60, 8'h77, 8'h00, -1, 2);  frame[3] = frame[3] ^ 8'h01; rx_pdu(0, 0);
    // R5 nonzero CPI with correct CRC
    make_frame(20, 8'h10, 8'h05, -1, 3);  rx_pdu(0, 0);
    // R6 zero, too large, pad too long
    make_frame(30, 8'h20, 8'h00, 0, 1);   rx_pdu(0, 0);
    make_frame(40, 8'h30, 8'h00, 41, 1);  rx_pdu(0, 0);
    make_frame(50, 8'h40, 8'h00, 10, 1);  rx_pdu(0, 0);
    // R8 abort, then recovery
    rx_abort(4);
    make_frame(88, 8'h99, 8'h00, -1, 11); rx_pdu(1, 2);

    while (exp_rx.size() != 0 || exp_tx.size() != 0 || exp_st.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule